// File: doc/BRIEF.md
# Programmable Ordered Dither Halftoner

This block turns a stream of 8-bit grayscale scanner pixels into a stream of 1-bit halftone pixels. Each pixel is compared with a threshold. The threshold is read from an 8x8 matrix of 8-bit entries that software loads through a simple write port. The matrix row is chosen by the scan-line count within the page, and the matrix column by the pixel count within the line. The threshold therefore tiles the page in two dimensions.

Pixels enter through a valid/ready port that carries start-of-line and start-of-page flags. Bits leave through a valid/ready port with a single registered stage. A mode input turns dithering off for content that is not halftone; the output is then a fixed mid-scale slice of the pixel.

Matrix writes go to a staging copy. The staging copy moves into the working copy when a page starts, so a page is always rendered with one consistent matrix.

Top module: `halftone_dither`

## Requirements
- R1: After reset, bit_valid_o is 0 and pix_ready_o is 1.
- R2: In dither mode (bypass_i = 0), the output bit is 1 when the pixel is greater than or equal to the working matrix entry at address row*8+column, and 0 otherwise.
- R3: The column is the number of pixels accepted since the last start-of-line or start-of-page pixel, modulo 8. The column wraps from 7 to 0 within long lines.
- R4: A pixel accepted with pix_sop_i set is at row 0, column 0. A pixel accepted with pix_sol_i set (and pix_sop_i clear) starts the next row, modulo 8. pix_sop_i takes priority over pix_sol_i.
- R5: A matrix write (cfg_we_i, 6-bit cfg_addr_i = row*8+column, 8-bit cfg_data_i) reaches the output only from the next accepted start-of-page pixel. A write in the same cycle as that pixel is held for the page after it.
- R6: Before the first start-of-page pixel after reset, the working matrix is all zeros, so every dithered output bit is 1.
- R7: With bypass_i = 1, the output bit is bit 7 of the pixel and the matrix is not used. Row and column counting still advance.
- R8: A pixel accepted at a clock edge shows up on bit_valid_o/bit_o right after that edge.
- R9: While bit_valid_o is 1 and bit_ready_i is 0, bit_o holds its value and pix_ready_o is 0. No pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | 1 = fixed mid-scale threshold, 0 = matrix dither |
| cfg_we_i | input | 1 | Matrix write strobe |
| cfg_addr_i | input | 6 | Matrix address, row*8+column |
| cfg_data_i | input | 8 | Matrix entry value |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Input pixel ready |
| pix_data_i | input | 8 | Grayscale pixel |
| pix_sol_i | input | 1 | Pixel is the first of a line |
| pix_sop_i | input | 1 | Pixel is the first of a page |
| bit_valid_o | output | 1 | Output bit valid |
| bit_ready_i | input | 1 | Output bit ready |
| bit_o | output | 1 | Halftone bit |

## Verification
Two events can fall in the same cycle: a matrix write and an accepted start-of-page pixel. A second collision is an output stall meeting a new input pixel. The bench provokes the first on purpose, writing address 0 exactly when the page-start pixel is accepted. It also drives random writes, line and page flags, and random output backpressure together for thousands of cycles. A behavioural model keeps a staging array and a working array and samples the staging array before applying the write. It also models the one-entry output stage. The model is compared with the ports on every clock.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int unsigned PIX_W_DEF   = 8;
  localparam int unsigned MAT_DIM_DEF = 8;

  typedef enum logic {
    MODE_DITHER = 1'b0,
    MODE_BYPASS = 1'b1
  } dith_mode_e;
endpackage

// File: rtl/dith_pos.sv
module dith_pos #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             sol_i,
  input  logic             sop_i,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o
);
  logic [IDX_W-1:0] row_q, col_q;

  // position of the pixel presented now
  always_comb begin
    if (sop_i) begin
      row_o = '0;
      col_o = '0;
    end else if (sol_i) begin
      row_o = row_q + 1'b1;
      col_o = '0;
    end else begin
      row_o = row_q;
      col_o = col_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv_i) begin
      row_q <= row_o;
      col_q <= col_o + 1'b1;
    end
  end

  assert_sop_home_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && sop_i |=> row_q == '0 && col_q == IDX_W'(1));

  assert_line_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && sol_i && !sop_i |=> row_q == IDX_W'($past(row_q) + 1'b1) && col_q == IDX_W'(1));

  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !sol_i && !sop_i |=> col_q == IDX_W'($past(col_q) + 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q) && $stable(col_q));
endmodule

// File: rtl/dith_matrix.sv
module dith_matrix #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned MAT_DIM = 8,
  localparam int unsigned IDX_W  = $clog2(MAT_DIM),
  localparam int unsigned ADDR_W = 2 * IDX_W,
  localparam int unsigned ENTRIES = MAT_DIM * MAT_DIM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [PIX_W-1:0]  wdata_i,
  input  logic              page_load_i,
  input  logic [IDX_W-1:0]  row_i,
  input  logic [IDX_W-1:0]  col_i,
  output logic [PIX_W-1:0]  thr_o
);
  logic [ENTRIES-1:0][PIX_W-1:0] stage_q, work_q;
  logic [ADDR_W-1:0] raddr;

  assign raddr = {row_i, col_i};
  // the page-start pixel sees the staged matrix it is about to latch
  assign thr_o = page_load_i ? stage_q[raddr] : work_q[raddr];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[e] <= '0;
      end else if (we_i && waddr_i == ADDR_W'(e)) begin
        stage_q[e] <= wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        work_q[e] <= '0;
      end else if (page_load_i) begin
        work_q[e] <= stage_q[e];
      end
    end
  end

  assert_work_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_load_i |=> $stable(work_q));

  assert_page_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_load_i |=> work_q == $past(stage_q));
endmodule

// File: rtl/dith_out.sv
module dith_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic bit_i,
  input  logic ready_i,
  output logic valid_o,
  output logic bit_o,
  output logic ready_o
);
  logic valid_q, bit_q;

  assign ready_o = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign bit_o   = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      bit_q   <= bit_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(bit_o));

  assert_no_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |-> !load_i);

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
endmodule

// File: rtl/halftone_dither.sv
module halftone_dither
  import dith_pkg::*;
#(
  parameter int unsigned PIX_W   = PIX_W_DEF,
  parameter int unsigned MAT_DIM = MAT_DIM_DEF,
  localparam int unsigned IDX_W  = $clog2(MAT_DIM),
  localparam int unsigned ADDR_W = 2 * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [PIX_W-1:0]  cfg_data_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic              pix_sol_i,
  input  logic              pix_sop_i,
  output logic              bit_valid_o,
  input  logic              bit_ready_i,
  output logic              bit_o
);
  logic             accept;
  logic [IDX_W-1:0] row, col;
  logic [PIX_W-1:0] thr;
  logic             dith_bit;
  dith_mode_e       mode;

  assign accept = pix_valid_i && pix_ready_o;
  assign mode   = dith_mode_e'(bypass_i);

  dith_pos #(.IDX_W(IDX_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .sol_i  (pix_sol_i),
    .sop_i  (pix_sop_i),
    .row_o  (row),
    .col_o  (col)
  );

  dith_matrix #(.PIX_W(PIX_W), .MAT_DIM(MAT_DIM)) u_mat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .waddr_i     (cfg_addr_i),
    .wdata_i     (cfg_data_i),
    .page_load_i (accept && pix_sop_i),
    .row_i       (row),
    .col_i       (col),
    .thr_o       (thr)
  );

  always_comb begin
    unique case (mode)
      MODE_BYPASS: dith_bit = pix_data_i[PIX_W-1];
      default:     dith_bit = (pix_data_i >= thr);
    endcase
  end

  dith_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .bit_i   (dith_bit),
    .ready_i (bit_ready_i),
    .valid_o (bit_valid_o),
    .bit_o   (bit_o),
    .ready_o (pix_ready_o)
  );

  assert_ready_when_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> pix_ready_o);

  assert_bypass_slice_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && bypass_i |=> bit_o == $past(pix_data_i[PIX_W-1]));
endmodule

// File: tb/tb_halftone_dither.sv
module tb_halftone_dither;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bypass_i = 1'b0, cfg_we_i = 1'b0;
  logic [5:0] cfg_addr_i = '0;
  logic [7:0] cfg_data_i = '0, pix_data_i = '0;
  logic pix_valid_i = 1'b0, pix_sol_i = 1'b0, pix_sop_i = 1'b0, bit_ready_i = 1'b1;
  logic pix_ready_o, bit_valid_o, bit_o;

  always #2 clk = ~clk;

  halftone_dither dut (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o), .pix_data_i(pix_data_i),
    .pix_sol_i(pix_sol_i), .pix_sop_i(pix_sop_i),
    .bit_valid_o(bit_valid_o), .bit_ready_i(bit_ready_i), .bit_o(bit_o)
  );

  int errors = 0, checks = 0;
  string ph = "R1";
  int sh[64], ac[64];
  int m_row = 0, m_col = 0;
  bit exp_valid = 0, exp_bit = 0;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", ph, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, bit sol, bit sop, bit we, int addr, int wd,
                      bit rdy, bit byp);
    bit exp_rdy, acc;
    int er, ec, thr;
    @(negedge clk);
    chk(bit_valid_o == exp_valid, "bit_valid_o", bit_valid_o, exp_valid);
    if (exp_valid) chk(bit_o == exp_bit, "bit_o", bit_o, exp_bit);
    pix_valid_i = v; pix_data_i = d; pix_sol_i = sol; pix_sop_i = sop;
    cfg_we_i = we; cfg_addr_i = 6'(addr); cfg_data_i = 8'(wd);
    bit_ready_i = rdy; bypass_i = byp;
    #1;
    exp_rdy = !exp_valid || rdy;
    chk(pix_ready_o == exp_rdy, "pix_ready_o", pix_ready_o, exp_rdy);
    acc = v && exp_rdy;
    if (acc) begin
      er = sop ? 0 : (sol ? (m_row + 1) % 8 : m_row);
      ec = (sop || sol) ? 0 : m_col;
      thr = sop ? sh[er*8+ec] : ac[er*8+ec];
      if (sop) for (int i = 0; i < 64; i++) ac[i] = sh[i];
      exp_bit = byp ? d[7] : (int'(d) >= thr);
      exp_valid = 1;
      m_row = er;
      m_col = (ec + 1) % 8;
    end else if (exp_valid && rdy) begin
      exp_valid = 0;
    end
    if (we) sh[addr] = wd;
  endtask

  task automatic line(int n, bit sop, bit byp);
    for (int i = 0; i < n; i++)
      step(1, 8'($urandom), i == 0, sop && i == 0, 0, 0, 0, 1, byp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog: done=0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin sh[i] = 0; ac[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    ph = "R1";
    chk(bit_valid_o == 0, "reset bit_valid_o", bit_valid_o, 0);
    chk(pix_ready_o == 1, "reset pix_ready_o", pix_ready_o, 1);

    ph = "R6";  // zero matrix before any page: all ones
    for (int i = 0; i < 10; i++) step(1, 8'(i * 23), 0, 0, 0, 0, 0, 1, 0);

    ph = "R2";
    for (int i = 0; i < 64; i++) step(0, 0, 0, 0, 1, i, (i * 37 + 11) & 255, 1, 0);
    for (int i = 0; i < 64; i++) step(1, 8'(i * 4), i % 8 == 0, i == 0, 0, 0, 0, 1, 0);

    ph = "R3";  // long and short lines, column wrap
    line(19, 1, 0); line(3, 0, 0); line(8, 0, 0); line(13, 0, 0);

    ph = "R4";  // row wrap past 8 lines, sop priority over sol
    line(9, 1, 0);
    for (int l = 0; l < 10; l++) line(9, 0, 0);
    step(1, 8'd200, 1, 1, 0, 0, 0, 1, 0);
    line(5, 0, 0);

    ph = "R5";  // mid-page writes, write colliding with page start
    for (int i = 0; i < 64; i++)
      step(1, 8'($urandom), i % 8 == 0, 0, 1, i, 255 - i * 3, 1, 0);
    line(8, 0, 0);
    step(1, 8'd128, 1, 1, 1, 0, 5, 1, 0);
    line(7, 0, 0); line(8, 0, 0);
    line(8, 1, 0);

    ph = "R7";
    line(8, 1, 1);
    for (int i = 0; i < 40; i++) step(1, 8'($urandom), i % 6 == 0, 0, 0, 0, 0, 1, 1'($urandom));

    ph = "R8";
    for (int i = 0; i < 200; i++)
      step(1'($urandom), 8'($urandom), ($urandom % 7) == 0, ($urandom % 50) == 0, 0, 0, 0, 1, 0);

    ph = "R9";
    for (int i = 0; i < 3000; i++)
      step(1'($urandom), 8'($urandom), ($urandom % 7) == 0, ($urandom % 60) == 0,
           ($urandom % 5) == 0, $urandom % 64, $urandom % 256,
           ($urandom % 3) != 0, ($urandom % 10) == 0);

    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule